// File: doc/BRIEF.md
# Byte-to-Word Assembler with ASCII Hex Decoding

This block sits behind a serial receiver and turns its byte stream into words of 8, 16 or 32 bits. In raw mode every received byte is one byte of the word. In hex mode every received byte is an ASCII character, and two hex characters make one byte. Three configuration inputs choose the word size, the byte order and raw or hex input.

When the last byte of a word arrives, the word is placed on a 32-bit output, zero-extended when it is shorter, together with a size tag and a one-cycle valid pulse. That pulse is the only event a consumer needs, so it can be used directly as an interrupt. A character that is not a hex digit raises an error pulse and drops the partial word. A synchronous clear input, or any change of configuration, also drops whatever has been gathered.

Top module: `byte_word_packer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, outValid and hexError are 0, and outWord and outSize are 0.
- R2: With cfgSize = 0 (8-bit) and cfgHex = 0, every accepted byte appears on outWord[7:0] with outWord[31:8] = 0, outSize = 0 and outValid high for exactly one cycle, one clock after the byte was accepted.
- R3: With cfgLsbFirst = 0, cfgSize = 1 (16-bit) gathers 2 bytes and cfgSize = 2 or 3 (32-bit) gathers 4 bytes; the first byte lands in the most significant position, and outSize is 1 or 2 respectively.
- R4: With cfgLsbFirst = 1 the first byte of a word lands in bits [7:0], the next in [15:8], and so on.
- R5: With cfgHex = 1, two characters form one byte, the first giving the upper nibble; digits 0-9 and letters a-f and A-F are accepted ("A8" and "a8" both give 0xA8).
- R6: Hex mode orders whole bytes, not nibbles: "ABCD" gives 0xABCD when most significant first and 0xCDAB when least significant first; "12345678" gives 0x12345678 and 0x78563412.
- R7: In hex mode a non-hex character makes hexError high for one cycle, one clock later, gives no outValid, and discards the partial word including a pending half byte.
- R8: A cycle with clear high discards the partial word, and a byte offered in that same cycle is dropped.
- R9: A change of any of cfgSize, cfgLsbFirst or cfgHex discards the partial word, as a clear would, in the first cycle the new value is present.
- R10: Cycles with inValid low leave the partial word intact; outWord and outSize hold their last values between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Discard the partial word |
| cfgSize | input | 2 | Word size: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| cfgLsbFirst | input | 1 | 1 = first byte is least significant |
| cfgHex | input | 1 | 1 = input bytes are ASCII hex characters |
| inValid | input | 1 | inByte is offered this cycle |
| inByte | input | 8 | Received byte or character |
| outValid | output | 1 | One-cycle pulse: a word is complete |
| outWord | output | 32 | Completed word, zero-extended |
| outSize | output | 2 | Size tag of outWord: 0, 1 or 2 |
| hexError | output | 1 | One-cycle pulse: a non-hex character was seen |

## Verification
On every cycle the assertions check that the byte counter never passes the last slot of the configured size, that raw mode never holds a pending half byte, that an error pulse and a valid pulse never coincide, that an 8-bit word is zero above bit 7, and that every valid or error pulse follows an accepted input in the cycle before. Byte placement, hex digit values, the discarding done by a clear, an error or a configuration change, and the holding of outputs across gaps can only be shown by the bench's scenarios against its queue-based reference model.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
  localparam int BYTE_W   = 8;
  localparam int MAX_BYTES = 4;
  localparam int WORD_W   = BYTE_W * MAX_BYTES;
  localparam int SLOT_W   = $clog2(MAX_BYTES);
  localparam int NIB_W    = BYTE_W / 2;

  localparam logic [1:0] SIZE_8  = 2'd0;
  localparam logic [1:0] SIZE_16 = 2'd1;
  localparam logic [1:0] SIZE_32 = 2'd2;

  typedef struct packed {
    logic              clr;
    logic              nibTake;
    logic              byteTake;
    logic              emit;
    logic              err;
    logic [SLOT_W-1:0] slot;
  } wpkStrobes_t;
endpackage

// File: rtl/wpk_ctrl.sv
module wpk_ctrl
  import wpk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic [1:0]  cfgSize,
  input  logic        cfgLsbFirst,
  input  logic        cfgHex,
  input  logic        inValid,
  input  logic        charIsHex,
  output wpkStrobes_t strobes
);
  localparam int CFG_W = 4;

  logic [CFG_W-1:0]  cfgQ;
  logic [CFG_W-1:0]  cfgNow;
  logic              cfgChange;
  logic [SLOT_W-1:0] slotCount;
  logic [SLOT_W-1:0] lastSlot;
  logic              nibPending;

  assign cfgNow    = {cfgSize, cfgLsbFirst, cfgHex};
  assign cfgChange = (cfgNow != cfgQ);

  always_comb begin
    case (cfgSize)
      SIZE_8:  lastSlot = SLOT_W'(0);
      SIZE_16: lastSlot = SLOT_W'(1);
      default: lastSlot = SLOT_W'(MAX_BYTES - 1);
    endcase
  end

  always_comb begin
    strobes          = '0;
    strobes.slot     = slotCount;
    if (clear || cfgChange) begin
      strobes.clr = 1'b1;
    end else if (inValid) begin
      if (cfgHex && !charIsHex) begin
        strobes.err = 1'b1;
        strobes.clr = 1'b1;
      end else if (cfgHex && !nibPending) begin
        strobes.nibTake = 1'b1;
      end else begin
        strobes.byteTake = 1'b1;
        strobes.emit     = (slotCount == lastSlot);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ       <= '0;
      slotCount  <= '0;
      nibPending <= 1'b0;
    end else begin
      cfgQ <= cfgNow;
      if (strobes.clr) begin
        slotCount  <= '0;
        nibPending <= 1'b0;
      end else if (strobes.nibTake) begin
        nibPending <= 1'b1;
      end else if (strobes.byteTake) begin
        nibPending <= 1'b0;
        slotCount  <= strobes.emit ? '0 : slotCount + 1'b1;
      end
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ == cfgNow) |-> (slotCount <= lastSlot));

  // R2
  raw_no_nibble_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgQ == cfgNow) && !cfgHex) |-> !nibPending);
endmodule

// File: rtl/wpk_datapath.sv
module wpk_datapath
  import wpk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  wpkStrobes_t        strobes,
  input  logic               cfgLsbFirst,
  input  logic               cfgHex,
  input  logic [1:0]         cfgSize,
  input  logic [BYTE_W-1:0]  inByte,
  output logic               charIsHex,
  output logic               outValid,
  output logic [WORD_W-1:0]  outWord,
  output logic [1:0]         outSize,
  output logic               hexError
);
  logic [NIB_W-1:0]  nibValue;
  logic [NIB_W-1:0]  upperNib;
  logic [BYTE_W-1:0] byteIn;
  logic [BYTE_W-1:0] accLane  [MAX_BYTES];
  logic [BYTE_W-1:0] nextLane [MAX_BYTES];
  logic [WORD_W-1:0] nextWord;

  always_comb begin
    charIsHex = 1'b1;
    nibValue  = '0;
    if (inByte >= 8'h30 && inByte <= 8'h39)
      nibValue = NIB_W'(inByte - 8'h30);
    else if (inByte >= 8'h41 && inByte <= 8'h46)
      nibValue = NIB_W'(inByte - 8'h37);
    else if (inByte >= 8'h61 && inByte <= 8'h66)
      nibValue = NIB_W'(inByte - 8'h57);
    else
      charIsHex = 1'b0;
  end

  assign byteIn = cfgHex ? {upperNib, nibValue} : inByte;

  generate
    for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
      if (k == 0) begin : g_first
        assign nextLane[k] = (cfgLsbFirst && strobes.slot != SLOT_W'(k)) ? accLane[k] : byteIn;
      end else begin : g_rest
        assign nextLane[k] = cfgLsbFirst
                           ? ((strobes.slot == SLOT_W'(k)) ? byteIn : accLane[k])
                           : accLane[k-1];
      end
      assign nextWord[k*BYTE_W +: BYTE_W] = nextLane[k];

      always_ff @(posedge clk) begin
        if (!rstN || strobes.clr || (strobes.byteTake && strobes.emit))
          accLane[k] <= '0;
        else if (strobes.byteTake)
          accLane[k] <= nextLane[k];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperNib <= '0;
      outValid <= 1'b0;
      outWord  <= '0;
      outSize  <= '0;
      hexError <= 1'b0;
    end else begin
      outValid <= strobes.byteTake && strobes.emit;
      hexError <= strobes.err;
      if (strobes.nibTake)
        upperNib <= nibValue;
      if (strobes.byteTake && strobes.emit) begin
        outWord <= nextWord;
        outSize <= (cfgSize == SIZE_8) ? SIZE_8 : (cfgSize == SIZE_16) ? SIZE_16 : SIZE_32;
      end
    end
  end

  // R7
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && hexError));

  // R2
  zero_extend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSize == SIZE_8) |-> (outWord[WORD_W-1:BYTE_W] == '0));

  // R3
  size_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outSize != 2'd3));
endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer
  import wpk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic [1:0]  cfgSize,
  input  logic        cfgLsbFirst,
  input  logic        cfgHex,
  input  logic        inValid,
  input  logic [7:0]  inByte,
  output logic        outValid,
  output logic [31:0] outWord,
  output logic [1:0]  outSize,
  output logic        hexError
);
  wpkStrobes_t strobes;
  logic        charIsHex;

  wpk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .clear       (clear),
    .cfgSize     (cfgSize),
    .cfgLsbFirst (cfgLsbFirst),
    .cfgHex      (cfgHex),
    .inValid     (inValid),
    .charIsHex   (charIsHex),
    .strobes     (strobes)
  );

  wpk_datapath u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cfgLsbFirst (cfgLsbFirst),
    .cfgHex      (cfgHex),
    .cfgSize     (cfgSize),
    .inByte      (inByte),
    .charIsHex   (charIsHex),
    .outValid    (outValid),
    .outWord     (outWord),
    .outSize     (outSize),
    .hexError    (hexError)
  );

  // R8
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(inValid) && !$past(clear)));

  // R7
  error_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    hexError |-> ($past(inValid) && $past(cfgHex)));
endmodule

// File: tb/byte_word_packer_bench.sv
`timescale 1ns/1ps
module byte_word_packer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0;
  logic [1:0]  cfgSize = 2'd0;
  logic        cfgLsbFirst = 1'b0;
  logic        cfgHex = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = 8'h00;
  logic        outValid;
  logic [31:0] outWord;
  logic [1:0]  outSize;
  logic        hexError;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string curReq = "R1";

  // reference model state
  byte unsigned q[$];
  int           pendNib = -1;
  logic [3:0]   prevCfg = 4'd0;
  logic         eValid = 1'b0;
  logic         eErr = 1'b0;
  logic [31:0]  eWord = 32'd0;
  logic [1:0]   eSize = 2'd0;

  // observed results
  logic [31:0] lastWord = 32'd0;
  logic [1:0]  lastSize = 2'd0;
  int          validSeen = 0;
  int          errSeen = 0;

  always #2 clk = ~clk;

  byte_word_packer u_byte_word_packer (
    .clk(clk), .rstN(rstN), .clear(clear), .cfgSize(cfgSize),
    .cfgLsbFirst(cfgLsbFirst), .cfgHex(cfgHex), .inValid(inValid),
    .inByte(inByte), .outValid(outValid), .outWord(outWord),
    .outSize(outSize), .hexError(hexError)
  );

  function automatic int hexVal(input byte unsigned c);
    if (c >= "0" && c <= "9") return int'(c) - 48;
    if (c >= "a" && c <= "f") return int'(c) - 87;
    if (c >= "A" && c <= "F") return int'(c) - 55;
    return -1;
  endfunction

  always @(posedge clk) begin
    int need;
    int v;
    logic [31:0] w;
    eValid = 1'b0;
    eErr   = 1'b0;
    if (!rstN) begin
      q.delete(); pendNib = -1; prevCfg = 4'd0; eWord = 0; eSize = 0;
    end else begin
      need = (cfgSize == 2'd0) ? 1 : (cfgSize == 2'd1) ? 2 : 4;
      if (clear || ({cfgSize, cfgLsbFirst, cfgHex} != prevCfg)) begin
        q.delete(); pendNib = -1;
      end else if (inValid) begin
        if (cfgHex) begin
          v = hexVal(inByte);
          if (v < 0) begin
            eErr = 1'b1; q.delete(); pendNib = -1;
          end else if (pendNib < 0) begin
            pendNib = v;
          end else begin
            q.push_back(byte'(pendNib * 16 + v)); pendNib = -1;
          end
        end else begin
          q.push_back(inByte);
        end
        if (q.size() == need) begin
          w = 0;
          for (int i = 0; i < need; i++) begin
            if (cfgLsbFirst) w = w | (32'(q[i]) << (8 * i));
            else             w = (w << 8) | 32'(q[i]);
          end
          eValid = 1'b1; eWord = w;
          eSize = (need == 1) ? 2'd0 : (need == 2) ? 2'd1 : 2'd2;
          q.delete();
        end
      end
      prevCfg = {cfgSize, cfgLsbFirst, cfgHex};
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (outValid !== eValid || hexError !== eErr || outWord !== eWord || outSize !== eSize) begin
      errors++;
      $display("FAIL %s model: actual v=%b e=%b w=%h s=%0d expected v=%b e=%b w=%h s=%0d",
               curReq, outValid, hexError, outWord, outSize, eValid, eErr, eWord, eSize);
    end
    if (outValid === 1'b1) begin lastWord = outWord; lastSize = outSize; validSeen++; end
    if (hexError === 1'b1) errSeen++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; inValid = 1'b0; clear = 1'b0;
    end
  endtask

  task automatic put(input byte unsigned b);
    @(posedge clk); #1; inValid = 1'b1; inByte = b; clear = 1'b0;
  endtask

  task automatic putStr(input string s);
    for (int i = 0; i < s.len(); i++) put(s[i]);
    idle(2);
  endtask

  task automatic setCfg(input logic [1:0] sz, input logic lsb, input logic hx);
    @(posedge clk); #1; inValid = 1'b0; cfgSize = sz; cfgLsbFirst = lsb; cfgHex = hx;
    idle(2);
  endtask

  initial begin
    while (cycles < 100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected <100000 cycles", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int vs;
    int es;
    idle(3);
    // R1: reset state
    check("R1", {30'd0, outValid, hexError}, 32'd0);
    check("R1", outWord, 32'd0);
    @(posedge clk); #1; rstN = 1'b1;
    @(negedge clk);
    check("R1", {28'd0, outSize, outValid, hexError}, 32'd0);

    curReq = "R2";
    setCfg(2'd0, 1'b0, 1'b0);
    put(8'h5A); idle(2);
    check("R2", lastWord, 32'h0000005A);
    check("R2", 32'(lastSize), 32'd0);
    put(8'hC3); put(8'h07); idle(2);
    check("R2", lastWord, 32'h00000007);

    curReq = "R3";
    setCfg(2'd1, 1'b0, 1'b0);
    put(8'h12); put(8'h34); idle(2);
    check("R3", lastWord, 32'h00001234);
    check("R3", 32'(lastSize), 32'd1);
    setCfg(2'd2, 1'b0, 1'b0);
    putStr("\x11\x22\x33\x44");
    check("R3", lastWord, 32'h11223344);
    check("R3", 32'(lastSize), 32'd2);
    setCfg(2'd3, 1'b0, 1'b0);
    putStr("\x01\x02\x03\x04");
    check("R3", lastWord, 32'h01020304);

    curReq = "R4";
    setCfg(2'd1, 1'b1, 1'b0);
    put(8'h12); put(8'h34); idle(2);
    check("R4", lastWord, 32'h00003412);
    setCfg(2'd2, 1'b1, 1'b0);
    putStr("\x11\x22\x33\x44");
    check("R4", lastWord, 32'h44332211);

    curReq = "R5";
    setCfg(2'd0, 1'b0, 1'b1);
    putStr("A8");
    check("R5", lastWord, 32'h000000A8);
    lastWord = 0;
    putStr("a8");
    check("R5", lastWord, 32'h000000A8);
    putStr("fF");
    check("R5", lastWord, 32'h000000FF);
    putStr("09");
    check("R5", lastWord, 32'h00000009);

    curReq = "R6";
    setCfg(2'd1, 1'b0, 1'b1);
    putStr("ABCD");
    check("R6", lastWord, 32'h0000ABCD);
    setCfg(2'd1, 1'b1, 1'b1);
    putStr("ABCD");
    check("R6", lastWord, 32'h0000CDAB);
    setCfg(2'd2, 1'b0, 1'b1);
    putStr("12345678");
    check("R6", lastWord, 32'h12345678);
    setCfg(2'd2, 1'b1, 1'b1);
    putStr("12345678");
    check("R6", lastWord, 32'h78563412);

    curReq = "R7";
    setCfg(2'd1, 1'b0, 1'b1);
    vs = validSeen; es = errSeen;
    putStr("AB5G");
    check("R7", 32'(errSeen - es), 32'd1);
    check("R7", 32'(validSeen - vs), 32'd0);
    putStr("1234");
    check("R7", lastWord, 32'h00001234);
    putStr("7z");
    putStr("9876");
    check("R7", lastWord, 32'h00009876);

    curReq = "R8";
    setCfg(2'd1, 1'b0, 1'b0);
    put(8'hAA);
    @(posedge clk); #1; inValid = 1'b0; clear = 1'b1;
    put(8'h01); put(8'h02); idle(2);
    check("R8", lastWord, 32'h00000102);
    put(8'hAA);
    @(posedge clk); #1; inValid = 1'b1; inByte = 8'hBB; clear = 1'b1;
    put(8'h03); put(8'h04); idle(2);
    check("R8", lastWord, 32'h00000304);

    curReq = "R9";
    setCfg(2'd2, 1'b0, 1'b0);
    put(8'hE1); put(8'hE2); idle(1);
    setCfg(2'd1, 1'b0, 1'b0);
    put(8'h05); put(8'h06); idle(2);
    check("R9", lastWord, 32'h00000506);
    put(8'hF0);
    setCfg(2'd1, 1'b1, 1'b0);
    put(8'h07); put(8'h08); idle(2);
    check("R9", lastWord, 32'h00000807);

    curReq = "R10";
    setCfg(2'd2, 1'b0, 1'b0);
    put(8'hDE); idle(3); put(8'hAD); idle(1); put(8'hBE); idle(4);
    vs = validSeen;
    put(8'hEF); idle(4);
    check("R10", lastWord, 32'hDEADBEEF);
    check("R10", 32'(validSeen - vs), 32'd1);
    check("R10", outWord, 32'hDEADBEEF);

    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule